// File: doc/BRIEF.md
# Machine trap CSR unit

This unit holds the machine-mode trap state of a small 32-bit RISC-V core. It holds the trap-vector base, the interrupt-enable and interrupt-pending registers, the status register fields used for trap handling, the exception PC and the cause. It also holds a backup set of registers that software cannot reach. With that backup, a non-maskable interrupt taken inside an ordinary trap handler can return without losing the handler's state.

The pipeline reaches the unit through a single-cycle CSR port and two trap strobes.
- **CSR port:** it carries an enable, an operation, a 12-bit address and write data. The read data and the illegal flag are combinational, and writes take effect at the next clock edge. The port has no valid/ready handshake and never exerts back-pressure: every access completes in the cycle it is presented.
- **Pipeline flush:** a write or bit-set to the status or interrupt-enable register raises a flush request one cycle later. This lets the pipeline observe a newly enabled interrupt before it issues younger instructions.
- **Interrupt output:** the unit presents the pending-and-enabled interrupt vector to the controller.

Top module: `mtrap_csr_unit`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, the trap-vector base equals the boot address with its low 8 bits cleared. The status, interrupt-enable, exception PC and cause registers read zero, and the flush output is 0.
- R2: A write, set or clear to the trap-vector register (address 0x305) updates bits 31:8 only. Bits 7:0 always read zero. The base changes only on such an access.
- R3: The flush output is 1 in the cycle after an enabled write or set to the status register (0x300) or the interrupt-enable register (0x304). Reads and clears of these registers, and accesses to any other address, leave it 0.
- R4: The operation encoding is 0 read (no write), 1 write, 2 set bits (old OR data) and 3 clear bits (old AND NOT data). The read data always shows the addressed register's value before the access.
- R5: The interrupt-enable register (0x304) implements bit 3 (software), bit 7 (timer), bit 11 (external) and bits 30:16 (15 fast lines). All other bits read zero.
- R6: In the interrupt-pending register (0x344), bit 3 is software-writable. Bits 7, 11 and 30:16 follow the timer, external and fast input lines, and software writes to those bits are ignored.
- R7: The interrupt output equals pending AND enable while the status MIE bit (bit 3) is 1, and zero while it is 0.
- R8: On trap entry, the exception PC (0x341) takes the trap PC and the cause (0x342) takes the trap cause. MPIE (status bit 7) takes MIE, MIE clears, and MPP (status bits 12:11) becomes 3.
- R9: On trap return, MIE takes MPIE and MPIE becomes 1. The return-PC output always shows the exception PC.
- R10: NMI entry copies MPP, MPIE, the exception PC and the cause into hidden backup registers. The first trap return after that entry applies R9 and then restores all four from the backup.
- R11: An access to any address other than the six implemented registers, including the hidden backup addresses 0x7C0 to 0x7C3, raises the illegal flag, reads zero and changes no state.
- R12: A trap entry or return in the same cycle as a CSR write to the status, exception PC or cause register takes priority, and the CSR write to that register is dropped. If entry and return arrive together, entry wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| boot_addr_i | input | 32 | Boot address, source of the reset trap-vector base |
| csr_en_i | input | 1 | CSR access in this cycle |
| csr_op_i | input | 2 | Operation: 0 read, 1 write, 2 set, 3 clear |
| csr_addr_i | input | 12 | CSR address |
| csr_wdata_i | input | 32 | Write data or bit mask |
| csr_rdata_o | output | 32 | Value of the addressed register |
| csr_illegal_o | output | 1 | Access to an unimplemented address |
| irq_timer_i | input | 1 | Timer interrupt line |
| irq_ext_i | input | 1 | External interrupt line |
| irq_fast_i | input | NUM_FAST | Fast local interrupt lines |
| trap_enter_i | input | 1 | Trap entry strobe |
| trap_nmi_i | input | 1 | Entry is a non-maskable interrupt |
| trap_pc_i | input | 32 | PC saved on entry |
| trap_cause_i | input | 32 | Cause saved on entry |
| trap_ret_i | input | 1 | Trap return strobe |
| tvec_base_o | output | 32 | Trap-vector base, 256-byte aligned |
| ret_pc_o | output | 32 | Return target (exception PC) |
| irq_pending_o | output | 32 | Pending, enabled and globally enabled interrupts |
| flush_o | output | 1 | Pipeline flush request |

## Verification
The bench targets the flush decision across all four operations on both critical registers and on their neighbours. A design that flushed on clears or reads would stall the pipeline without need, and one that missed set operations would let an interrupt enabled by a set-bit instruction go unseen. It nests an NMI inside an ordinary trap after software has changed MPP and MIE. The check is that the return restores the outer handler's MPIE, MPP, exception PC and cause; a missing backup returns to the NMI's own PC. It also writes the exception PC in the same cycle as a trap entry, writes all ones into the pending register while the lines are low, and touches the hidden backup addresses. Each of these would show up as wrong read data, a stray interrupt bit or a state change after an illegal access.

// File: rtl/mtrap_pkg.sv
package mtrap_pkg;

  localparam int XLEN = 32;

  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WRITE = 2'd1,
    OP_SET   = 2'd2,
    OP_CLEAR = 2'd3
  } csr_op_e;

  localparam logic [11:0] A_STATUS = 12'h300;
  localparam logic [11:0] A_IE     = 12'h304;
  localparam logic [11:0] A_TVEC   = 12'h305;
  localparam logic [11:0] A_EPC    = 12'h341;
  localparam logic [11:0] A_CAUSE  = 12'h342;
  localparam logic [11:0] A_IP     = 12'h344;

  localparam int B_MIE  = 3;
  localparam int B_MPIE = 7;
  localparam int B_MPP  = 11;

  localparam int I_SW   = 3;
  localparam int I_TIM  = 7;
  localparam int I_EXT  = 11;
  localparam int I_FAST = 16;

  function automatic logic [XLEN-1:0] irq_mask(input int nfast);
    logic [XLEN-1:0] m;
    m = '0;
    m[I_SW]  = 1'b1;
    m[I_TIM] = 1'b1;
    m[I_EXT] = 1'b1;
    for (int k = 0; k < nfast; k++) m[I_FAST+k] = 1'b1;
    return m;
  endfunction

  function automatic logic [XLEN-1:0] apply_op(input csr_op_e op,
                                               input logic [XLEN-1:0] old_v,
                                               input logic [XLEN-1:0] wd);
    case (op)
      OP_WRITE: return wd;
      OP_SET:   return old_v | wd;
      OP_CLEAR: return old_v & ~wd;
      default:  return old_v;
    endcase
  endfunction

endpackage

// File: rtl/mtrap_tvec.sv
module mtrap_tvec
  import mtrap_pkg::*;
#(
  parameter int ALIGN_BITS = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [XLEN-1:0] boot_addr_i,
  input  logic            we_i,
  input  logic [XLEN-1:0] wval_i,
  output logic [XLEN-1:0] tvec_o
);
  localparam logic [XLEN-1:0] LOW_MASK = XLEN'((64'd1 << ALIGN_BITS) - 64'd1);
  localparam logic [XLEN-1:0] HI_MASK  = ~LOW_MASK;

  logic [XLEN-1:0] tvec_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   tvec_q <= boot_addr_i & HI_MASK;
    else if (we_i) tvec_q <= wval_i & HI_MASK;
  end

  assign tvec_o = tvec_q;

  assert_tvec_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(tvec_o));

endmodule

// File: rtl/mtrap_irq.sv
module mtrap_irq
  import mtrap_pkg::*;
#(
  parameter int NUM_FAST = 15
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                ie_we_i,
  input  logic                ip_we_i,
  input  logic [XLEN-1:0]     wval_i,
  input  logic                irq_timer_i,
  input  logic                irq_ext_i,
  input  logic [NUM_FAST-1:0] irq_fast_i,
  input  logic                gmie_i,
  output logic [XLEN-1:0]     ie_o,
  output logic [XLEN-1:0]     ip_o,
  output logic [XLEN-1:0]     pend_o
);
  localparam logic [XLEN-1:0] IE_MASK = irq_mask(NUM_FAST);

  logic [XLEN-1:0] ie_q;
  logic            sw_q;
  logic [XLEN-1:0] ip_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ie_q <= '0;
      sw_q <= 1'b0;
    end else begin
      if (ie_we_i) ie_q <= wval_i & IE_MASK;
      if (ip_we_i) sw_q <= wval_i[I_SW];
    end
  end

  always_comb begin
    ip_w        = '0;
    ip_w[I_SW]  = sw_q;
    ip_w[I_TIM] = irq_timer_i;
    ip_w[I_EXT] = irq_ext_i;
  end

  logic [XLEN-1:0] ip_full;
  genvar g;
  generate
    for (g = 0; g < XLEN; g++) begin : g_ip
      if (g >= I_FAST && g < I_FAST + NUM_FAST) begin : g_fast
        assign ip_full[g] = irq_fast_i[g-I_FAST];
      end else begin : g_other
        assign ip_full[g] = ip_w[g];
      end
    end
  endgenerate

  assign ie_o   = ie_q;
  assign ip_o   = ip_full;
  assign pend_o = gmie_i ? (ip_full & ie_q) : '0;

  assert_ie_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ie_we_i |=> $stable(ie_o));

  assert_sw_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ip_we_i |=> $stable(ip_o[I_SW]));

  assert_gate_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gmie_i |-> (pend_o == '0));

endmodule

// File: rtl/mtrap_status.sv
module mtrap_status
  import mtrap_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_status_i,
  input  logic            we_epc_i,
  input  logic            we_cause_i,
  input  logic [XLEN-1:0] wval_i,
  input  logic            trap_enter_i,
  input  logic            trap_nmi_i,
  input  logic [XLEN-1:0] trap_pc_i,
  input  logic [XLEN-1:0] trap_cause_i,
  input  logic            trap_ret_i,
  output logic [XLEN-1:0] status_o,
  output logic [XLEN-1:0] epc_o,
  output logic [XLEN-1:0] cause_o
);
  localparam logic [XLEN-1:0] ST_MASK =
    (XLEN'(1) << B_MIE) | (XLEN'(1) << B_MPIE) | (XLEN'(3) << B_MPP);

  logic [XLEN-1:0] status_q, epc_q, cause_q;
  logic [1:0]      bk_mpp_q;
  logic            bk_mpie_q;
  logic [XLEN-1:0] bk_epc_q, bk_cause_q;
  logic            nmi_act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q   <= '0;
      epc_q      <= '0;
      cause_q    <= '0;
      bk_mpp_q   <= '0;
      bk_mpie_q  <= 1'b0;
      bk_epc_q   <= '0;
      bk_cause_q <= '0;
      nmi_act_q  <= 1'b0;
    end else if (trap_enter_i) begin
      if (trap_nmi_i) begin
        bk_mpp_q   <= status_q[B_MPP +: 2];
        bk_mpie_q  <= status_q[B_MPIE];
        bk_epc_q   <= epc_q;
        bk_cause_q <= cause_q;
        nmi_act_q  <= 1'b1;
      end
      epc_q                <= trap_pc_i;
      cause_q              <= trap_cause_i;
      status_q[B_MPIE]     <= status_q[B_MIE];
      status_q[B_MIE]      <= 1'b0;
      status_q[B_MPP +: 2] <= 2'b11;
    end else if (trap_ret_i) begin
      status_q[B_MIE] <= status_q[B_MPIE];
      if (nmi_act_q) begin
        status_q[B_MPIE]     <= bk_mpie_q;
        status_q[B_MPP +: 2] <= bk_mpp_q;
        epc_q                <= bk_epc_q;
        cause_q              <= bk_cause_q;
        nmi_act_q            <= 1'b0;
      end else begin
        status_q[B_MPIE] <= 1'b1;
      end
    end else begin
      if (we_status_i) status_q <= wval_i & ST_MASK;
      if (we_epc_i)    epc_q    <= wval_i;
      if (we_cause_i)  cause_q  <= wval_i;
    end
  end

  assign status_o = status_q;
  assign epc_o    = epc_q;
  assign cause_o  = cause_q;

  assert_entry_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_enter_i |=> (!status_o[B_MIE] && status_o[B_MPP +: 2] == 2'b11));

  assert_entry_wins_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_enter_i |=> (epc_o == $past(trap_pc_i) && cause_o == $past(trap_cause_i)));

  assert_return_mie_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trap_ret_i && !trap_enter_i) |=> (status_o[B_MIE] == $past(status_o[B_MPIE])));

  assert_nmi_restore_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trap_ret_i && !trap_enter_i && nmi_act_q) |=> (epc_o == $past(bk_epc_q)));

endmodule

// File: rtl/mtrap_csr_unit.sv
module mtrap_csr_unit
  import mtrap_pkg::*;
#(
  parameter int NUM_FAST   = 15,
  parameter int ALIGN_BITS = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [XLEN-1:0]     boot_addr_i,
  input  logic                csr_en_i,
  input  logic [1:0]          csr_op_i,
  input  logic [11:0]         csr_addr_i,
  input  logic [XLEN-1:0]     csr_wdata_i,
  output logic [XLEN-1:0]     csr_rdata_o,
  output logic                csr_illegal_o,
  input  logic                irq_timer_i,
  input  logic                irq_ext_i,
  input  logic [NUM_FAST-1:0] irq_fast_i,
  input  logic                trap_enter_i,
  input  logic                trap_nmi_i,
  input  logic [XLEN-1:0]     trap_pc_i,
  input  logic [XLEN-1:0]     trap_cause_i,
  input  logic                trap_ret_i,
  output logic [XLEN-1:0]     tvec_base_o,
  output logic [XLEN-1:0]     ret_pc_o,
  output logic [XLEN-1:0]     irq_pending_o,
  output logic                flush_o
);
  csr_op_e         op;
  logic            legal;
  logic [XLEN-1:0] cur, wval;
  logic            we;
  logic [XLEN-1:0] status_w, epc_w, cause_w, ie_w, ip_w, tvec_w;
  logic            flush_q, flush_d;

  assign op = csr_op_e'(csr_op_i);

  always_comb begin
    legal = 1'b1;
    case (csr_addr_i)
      A_STATUS: cur = status_w;
      A_IE:     cur = ie_w;
      A_TVEC:   cur = tvec_w;
      A_EPC:    cur = epc_w;
      A_CAUSE:  cur = cause_w;
      A_IP:     cur = ip_w;
      default: begin
        cur   = '0;
        legal = 1'b0;
      end
    endcase
  end

  assign wval          = apply_op(op, cur, csr_wdata_i);
  assign we            = csr_en_i && legal && (op != OP_READ);
  assign csr_rdata_o   = cur;
  assign csr_illegal_o = csr_en_i && !legal;

  assign flush_d = csr_en_i && (op == OP_WRITE || op == OP_SET) &&
                   (csr_addr_i == A_STATUS || csr_addr_i == A_IE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flush_q <= 1'b0;
    else         flush_q <= flush_d;
  end
  assign flush_o = flush_q;

  mtrap_tvec #(.ALIGN_BITS(ALIGN_BITS)) u_tvec (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .boot_addr_i (boot_addr_i),
    .we_i        (we && csr_addr_i == A_TVEC),
    .wval_i      (wval),
    .tvec_o      (tvec_w)
  );

  mtrap_irq #(.NUM_FAST(NUM_FAST)) u_irq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ie_we_i     (we && csr_addr_i == A_IE),
    .ip_we_i     (we && csr_addr_i == A_IP),
    .wval_i      (wval),
    .irq_timer_i (irq_timer_i),
    .irq_ext_i   (irq_ext_i),
    .irq_fast_i  (irq_fast_i),
    .gmie_i      (status_w[B_MIE]),
    .ie_o        (ie_w),
    .ip_o        (ip_w),
    .pend_o      (irq_pending_o)
  );

  mtrap_status u_status (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .we_status_i  (we && csr_addr_i == A_STATUS),
    .we_epc_i     (we && csr_addr_i == A_EPC),
    .we_cause_i   (we && csr_addr_i == A_CAUSE),
    .wval_i       (wval),
    .trap_enter_i (trap_enter_i),
    .trap_nmi_i   (trap_nmi_i),
    .trap_pc_i    (trap_pc_i),
    .trap_cause_i (trap_cause_i),
    .trap_ret_i   (trap_ret_i),
    .status_o     (status_w),
    .epc_o        (epc_w),
    .cause_o      (cause_w)
  );

  assign tvec_base_o = tvec_w;
  assign ret_pc_o    = epc_w;

  assert_flush_source_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |-> $past(csr_en_i && (csr_op_i == 2'd1 || csr_op_i == 2'd2) &&
                      (csr_addr_i == A_STATUS || csr_addr_i == A_IE)));

  assert_illegal_reads_zero_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    csr_illegal_o |-> (csr_rdata_o == '0));

  assert_illegal_no_write_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    csr_illegal_o |=> ($stable(tvec_base_o) && $stable(u_irq.ie_o)));

endmodule

// File: tb/mtrap_csr_unit_bench.sv
module mtrap_csr_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] boot = 32'h8000_1234;
  logic        en = 0;
  logic [1:0]  op = 0;
  logic [11:0] addr = 0;
  logic [31:0] wd = 0;
  logic        tim = 0, ext = 0;
  logic [14:0] fast = 0;
  logic        tenter = 0, tnmi = 0, tret = 0;
  logic [31:0] tpc = 0, tcause = 0;
  logic [31:0] rdata, tvec, retpc, irq;
  logic        illegal, flush;

  always #10 clk = ~clk;

  mtrap_csr_unit u_mtrap_csr_unit (
    .clk_i(clk), .rst_ni(rst_n), .boot_addr_i(boot),
    .csr_en_i(en), .csr_op_i(op), .csr_addr_i(addr), .csr_wdata_i(wd),
    .csr_rdata_o(rdata), .csr_illegal_o(illegal),
    .irq_timer_i(tim), .irq_ext_i(ext), .irq_fast_i(fast),
    .trap_enter_i(tenter), .trap_nmi_i(tnmi), .trap_pc_i(tpc),
    .trap_cause_i(tcause), .trap_ret_i(tret),
    .tvec_base_o(tvec), .ret_pc_o(retpc), .irq_pending_o(irq), .flush_o(flush)
  );

  int n_chk = 0, n_fail = 0;

  // reference state
  logic [31:0] m_tvec, m_ie, m_epc, m_cause, b_epc, b_cause;
  logic        m_mie, m_mpie, m_sw, m_fl, b_mpie, m_nact;
  logic [1:0]  m_mpp, b_mpp;

  function automatic bit m_legal(input logic [11:0] a);
    return a == 12'h300 || a == 12'h304 || a == 12'h305 ||
           a == 12'h341 || a == 12'h342 || a == 12'h344;
  endfunction

  function automatic logic [31:0] m_ip();
    return ({31'b0, m_sw} << 3) | ({31'b0, tim} << 7) | ({31'b0, ext} << 11) |
           ({17'b0, fast} << 16);
  endfunction

  function automatic logic [31:0] m_read(input logic [11:0] a);
    case (a)
      12'h300: return ({30'b0, m_mpp} << 11) | ({31'b0, m_mpie} << 7) | ({31'b0, m_mie} << 3);
      12'h304: return m_ie;
      12'h305: return m_tvec;
      12'h341: return m_epc;
      12'h342: return m_cause;
      12'h344: return m_ip();
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk) begin
    logic [31:0] cur, nv;
    bit wr;
    if (!rst_n) begin
      m_tvec = boot & 32'hFFFF_FF00; m_ie = 0; m_epc = 0; m_cause = 0;
      m_mie = 0; m_mpie = 0; m_mpp = 0; m_sw = 0; m_fl = 0;
      b_epc = 0; b_cause = 0; b_mpie = 0; b_mpp = 0; m_nact = 0;
    end else begin
      cur = m_read(addr);
      wr  = en && m_legal(addr) && op != 2'd0;
      case (op)
        2'd1: nv = wd;
        2'd2: nv = cur | wd;
        2'd3: nv = cur & ~wd;
        default: nv = cur;
      endcase
      m_fl = en && (addr == 12'h300 || addr == 12'h304) && (op == 2'd1 || op == 2'd2);
      if (wr && addr == 12'h305) m_tvec = nv & 32'hFFFF_FF00;
      if (wr && addr == 12'h304) m_ie = nv & 32'h7FFF_0888;
      if (wr && addr == 12'h344) m_sw = nv[3];
      if (tenter) begin
        if (tnmi) begin
          b_mpp = m_mpp; b_mpie = m_mpie; b_epc = m_epc; b_cause = m_cause; m_nact = 1;
        end
        m_epc = tpc; m_cause = tcause; m_mpie = m_mie; m_mie = 0; m_mpp = 2'b11;
      end else if (tret) begin
        m_mie = m_mpie;
        if (m_nact) begin
          m_mpie = b_mpie; m_mpp = b_mpp; m_epc = b_epc; m_cause = b_cause; m_nact = 0;
        end else m_mpie = 1;
      end else if (wr) begin
        if (addr == 12'h300) begin m_mie = nv[3]; m_mpie = nv[7]; m_mpp = nv[12:11]; end
        if (addr == 12'h341) m_epc = nv;
        if (addr == 12'h342) m_cause = nv;
      end
    end
  end

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic compare_all();
    check("R4 rdata", rdata, m_read(addr));
    check("R11 illegal", {31'b0, illegal}, {31'b0, en && !m_legal(addr)});
    check("R2 tvec", tvec, m_tvec);
    check("R7 irq", irq, m_mie ? (m_ip() & m_ie) : 32'h0);
    check("R9 ret_pc", retpc, m_epc);
    check("R3 flush", {31'b0, flush}, {31'b0, m_fl});
  endtask

  // settle, compare, advance to the next falling edge
  task automatic go();
    #2 compare_all();
    @(negedge clk);
  endtask

  task automatic csr(input logic [1:0] o, input logic [11:0] a, input logic [31:0] d);
    en = 1; op = o; addr = a; wd = d; tenter = 0; tret = 0; tnmi = 0;
    go();
    en = 0; op = 0;
  endtask

  task automatic expect_rd(input string tag, input logic [11:0] a, input logic [31:0] exp);
    en = 1; op = 0; addr = a; tenter = 0; tret = 0;
    #2 check(tag, rdata, exp);
    go();
    en = 0;
  endtask

  task automatic trap(input bit nmi, input logic [31:0] pc, input logic [31:0] c);
    tenter = 1; tnmi = nmi; tpc = pc; tcause = c;
    go();
    tenter = 0; tnmi = 0;
  endtask

  task automatic mret();
    tret = 1;
    go();
    tret = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got hang expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #2 check("R1 flush in reset", {31'b0, flush}, 32'h0);
    check("R1 tvec in reset", tvec, 32'h8000_1200);
    @(negedge clk);
    rst_n = 1;
    expect_rd("R1 tvec", 12'h305, 32'h8000_1200);
    expect_rd("R1 status", 12'h300, 32'h0);
    expect_rd("R1 ie", 12'h304, 32'h0);

    // R2 alignment and read-modify ops (R4)
    csr(2'd1, 12'h305, 32'h0000_4ABC);
    expect_rd("R2 tvec write", 12'h305, 32'h0000_4A00);
    csr(2'd2, 12'h305, 32'h00F0_0000);
    csr(2'd3, 12'h305, 32'h0000_4000);
    expect_rd("R4 set/clear", 12'h305, 32'h00F0_0A00);

    // R5 mask and R3 flush
    csr(2'd1, 12'h304, 32'hFFFF_FFFF);
    #2 check("R3 flush after ie write", {31'b0, flush}, 32'h1);
    expect_rd("R5 ie mask", 12'h304, 32'h7FFF_0888);
    csr(2'd3, 12'h304, 32'h0000_0080);
    #2 check("R3 no flush on clear", {31'b0, flush}, 32'h0);
    csr(2'd0, 12'h300, 32'hFFFF_FFFF);
    #2 check("R3 no flush on read", {31'b0, flush}, 32'h0);
    csr(2'd1, 12'h341, 32'h0);
    #2 check("R3 no flush other addr", {31'b0, flush}, 32'h0);

    // R6 pending mirrors
    csr(2'd1, 12'h344, 32'hFFFF_FFFF);
    expect_rd("R6 ip ignores ro bits", 12'h344, 32'h0000_0008);
    tim = 1; fast = 15'h4001;
    expect_rd("R6 ip lines", 12'h344, 32'h4001_0088);
    #2 check("R7 gated off", irq, 32'h0);
    csr(2'd2, 12'h300, 32'h0000_0008);
    #2 check("R3 flush on status set", {31'b0, flush}, 32'h1);
    check("R7 gated on", irq, 32'h4001_0008);

    // R8/R9 plain trap
    trap(0, 32'h100, 32'h8000_000B);
    expect_rd("R8 status", 12'h300, 32'h0000_1880);
    expect_rd("R8 epc", 12'h341, 32'h100);
    expect_rd("R8 cause", 12'h342, 32'h8000_000B);
    mret();
    expect_rd("R9 status", 12'h300, 32'h0000_1888);
    #2 check("R9 ret pc", retpc, 32'h100);

    // R10 nested NMI
    tim = 0; fast = 0;
    trap(0, 32'h200, 32'h2);
    csr(2'd1, 12'h300, 32'h0000_0008);
    trap(1, 32'h300, 32'h8000_001F);
    expect_rd("R10 nmi status", 12'h300, 32'h0000_1880);
    mret();
    expect_rd("R10 restored status", 12'h300, 32'h0000_0008);
    expect_rd("R10 restored epc", 12'h341, 32'h200);
    expect_rd("R10 restored cause", 12'h342, 32'h2);

    // R11 hidden and unknown addresses
    en = 1; op = 0; addr = 12'h7C0;
    #2 check("R11 illegal flag", {31'b0, illegal}, 32'h1);
    check("R11 reads zero", rdata, 32'h0);
    go();
    csr(2'd1, 12'h7C1, 32'hFFFF_FFFF);
    expect_rd("R11 no side effect", 12'h341, 32'h200);

    // R12 trap beats CSR write
    en = 1; op = 2'd1; addr = 12'h341; wd = 32'hDEAD_0000;
    tenter = 1; tpc = 32'h400; tcause = 32'h5;
    go();
    en = 0; tenter = 0;
    expect_rd("R12 epc from trap", 12'h341, 32'h400);

    // mixed traffic against the model
    for (int i = 0; i < 600; i++) begin
      logic [11:0] al [8];
      al = '{12'h300, 12'h304, 12'h305, 12'h341, 12'h342, 12'h344, 12'h7C2, 12'h123};
      en = $urandom_range(0, 1); op = 2'($urandom); addr = al[$urandom_range(0, 7)];
      wd = $urandom; tim = $urandom_range(0, 1); ext = $urandom_range(0, 1);
      fast = 15'($urandom);
      tenter = ($urandom_range(0, 9) == 0); tnmi = $urandom_range(0, 1);
      tret = ($urandom_range(0, 9) == 0); tpc = $urandom; tcause = $urandom;
      go();
    end
    en = 0; tenter = 0; tret = 0;
    go();

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule